// File: doc/BRIEF.md
# Interrupt-Capable Pin Bank

This block is a register-mapped bank of general-purpose pins. Software sets, pin by pin, whether the pin is driven and at what level. It can also hand a pin to another on-chip peripheral, which then supplies that pin's level and enable. Two system mode inputs change what drives the pins. In sleep mode the pins take a separate set of stored sleep levels. In battery-fault mode they take a third set, and battery-fault mode wins over sleep mode.

Every pin input passes through a synchronizer. Each pin can then flag an event, either on a level or on an edge, with a polarity chosen per pin. Event flags are sticky and are cleared by writing ones to them. The single bank interrupt output is raised while any flag is set and not blocked. In normal mode the blocking comes from the normal block register; in sleep mode it comes from the sleep block register.

Software reaches the bank through a simple word-addressed register port. A write is accepted on a clock edge with the write strobe high. A read returns its data registered one edge after the read strobe.

Top module: `pinbank_top`

## Requirements
- R1: After reset the interrupt block and sleep block registers read 0xFFFF, every other writable register reads 0, no pin is driven (`pin_oe` = 0) and `irq` is low.
- R2: The writable registers sit at byte offsets 0x00 block, 0x04 direction, 0x08 level, 0x0C trigger kind, 0x10 edge polarity, 0x14 level polarity, 0x18 sleep block, 0x1C sleep level, 0x20 battery-fault level, 0x28 peripheral select and 0x2C sleep override. Each reads back the low 16 bits last written, with bits 31..16 as 0. `bus_rdata` is loaded on the edge where `bus_rd` is high and holds otherwise.
- R3: Offset 0x30 is read-only and returns the pin inputs as seen after a two-flop synchronizer. A write to it changes nothing.
- R4: In normal mode, with the select bit at 0, direction bit 1 drives the pin (`pin_oe`=1) and direction 0 leaves it as an input. `pin_out` equals the level register bit.
- R5: In normal mode a pin whose peripheral-select bit is 1 takes `pin_out` and `pin_oe` from `alt_out` and `alt_oe`.
- R6: While `sleep_in` is high, or for a pin whose sleep-override bit is 1, `pin_out` equals the sleep level bit and `pin_oe` equals the direction bit, whatever the select bit.
- R7: While `batt_fault_in` is high, `pin_out` equals the battery-fault level bit and `pin_oe` equals the direction bit, even when `sleep_in` is also high.
- R8: With trigger kind 1 (edge), a pin's flag at offset 0x24 sets on a rising edge when its edge polarity is 1 and on a falling edge when it is 0. An edge of the other direction does not set it.
- R9: With trigger kind 0 (level), a pin's flag sets while the synchronized level is high when its level polarity is 1, and while it is low when the polarity is 0.
- R10: Flags are sticky. Writing 1 to a flag bit clears it and writing 0 leaves it. A level condition that is still true sets the flag again on the clear edge.
- R11: `irq` is high exactly when some flag is set whose block bit is 0. The block bit comes from offset 0x00 in normal mode and from offset 0x18 while `sleep_in` is high.
- R12: Offsets 0x34 to 0x3C read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Levels to drive on the pads |
| pin_oe | output | 16 | Pad drive enables |
| alt_out | input | 16 | Levels from the peripheral that owns a pin |
| alt_oe | input | 16 | Drive enables from the peripheral that owns a pin |
| sleep_in | input | 1 | Sleep mode |
| batt_fault_in | input | 1 | Battery-fault mode |
| irq | output | 1 | Bank interrupt |

## Verification
Every cycle, the assertions check the following. The synchronizer delivers the pin levels of two edges earlier. A set flag only drops on an edge that writes a 1 to it. `irq` never rises without a flag behind it. Battery-fault and sleep modes take over the pin drive, and read data holds when no read is made. Only the bench's scenarios can show that each edge polarity and level polarity catches the right event and ignores the opposite one. They also show that a held level defeats a clear, and that the sleep block register replaces the normal one in sleep mode. The remaining scenario checks cover read-back at every offset and the read-only and unmapped addresses.

// File: rtl/pinbank_pkg.sv
// Shared definitions for the pin bank: the word index of each register.
// Assumes the word index is the byte address shifted right by two.
package pinbank_pkg;

    typedef enum logic [3:0] {
        RG_BLOCK  = 4'd0,
        RG_DIR    = 4'd1,
        RG_LEVEL  = 4'd2,
        RG_KIND   = 4'd3,
        RG_EPOL   = 4'd4,
        RG_LPOL   = 4'd5,
        RG_SBLOCK = 4'd6,
        RG_SLEVEL = 4'd7,
        RG_FLEVEL = 4'd8,
        RG_FLAG   = 4'd9,
        RG_SEL    = 4'd10,
        RG_SOVR   = 4'd11,
        RG_PINS   = 4'd12
    } reg_idx_e;

    localparam int unsigned LAST_IDX = 12;

endpackage

// File: rtl/pinbank_sync.sv
// Input synchronizer: a chain of STAGES flops per pin.
// Assumes pin levels are asynchronous to clk; output is STAGES edges late.
module pinbank_sync #(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_sync
);

    logic [NPINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_next
            // Later stages shift the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_chk
        AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (pin_sync == $past(pin_in, 2))); // R3
    end

endmodule

// File: rtl/pinbank_regs.sv
// Register file and read port of the pin bank.
// Assumes single-cycle strobes; read data is registered on the read edge.
// The flag register lives in the event unit; this block only forwards
// write-one-to-clear pulses to it and reads it back.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  flag_q,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [NPINS-1:0]  block_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  level_q,
    output logic [NPINS-1:0]  kind_q,
    output logic [NPINS-1:0]  epol_q,
    output logic [NPINS-1:0]  lpol_q,
    output logic [NPINS-1:0]  sblock_q,
    output logic [NPINS-1:0]  slevel_q,
    output logic [NPINS-1:0]  flevel_q,
    output logic [NPINS-1:0]  sel_q,
    output logic [NPINS-1:0]  sovr_q,
    output logic [NPINS-1:0]  flag_clr
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic [NPINS-1:0]  wval;
    logic [DATA_W-1:0] rd_word;
    logic              unmapped;
    logic              unused_bits;

    assign widx        = addr[ADDR_W-1:2];
    assign wval        = wdata[NPINS-1:0];
    assign unmapped    = (widx > IDX_W'(LAST_IDX));
    assign unused_bits = ^{wdata, addr[1:0]};

    function automatic logic hit(input reg_idx_e r);
        return widx == IDX_W'(r);
    endfunction

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q  <= '1;
            dir_q    <= '0;
            level_q  <= '0;
            kind_q   <= '0;
            epol_q   <= '0;
            lpol_q   <= '0;
            sblock_q <= '1;
            slevel_q <= '0;
            flevel_q <= '0;
            sel_q    <= '0;
            sovr_q   <= '0;
        end else if (wr) begin
            if (hit(RG_BLOCK))  block_q  <= wval;
            if (hit(RG_DIR))    dir_q    <= wval;
            if (hit(RG_LEVEL))  level_q  <= wval;
            if (hit(RG_KIND))   kind_q   <= wval;
            if (hit(RG_EPOL))   epol_q   <= wval;
            if (hit(RG_LPOL))   lpol_q   <= wval;
            if (hit(RG_SBLOCK)) sblock_q <= wval;
            if (hit(RG_SLEVEL)) slevel_q <= wval;
            if (hit(RG_FLEVEL)) flevel_q <= wval;
            if (hit(RG_SEL))    sel_q    <= wval;
            if (hit(RG_SOVR))   sovr_q   <= wval;
        end
    end

    // Write-one-to-clear pulses for the flag register.
    always_comb begin
        flag_clr = '0;
        if (wr && hit(RG_FLAG)) flag_clr = wval;
    end

    // Read multiplexer; unmapped words return zero.
    always_comb begin
        rd_word = '0;
        if      (hit(RG_BLOCK))  rd_word[NPINS-1:0] = block_q;
        else if (hit(RG_DIR))    rd_word[NPINS-1:0] = dir_q;
        else if (hit(RG_LEVEL))  rd_word[NPINS-1:0] = level_q;
        else if (hit(RG_KIND))   rd_word[NPINS-1:0] = kind_q;
        else if (hit(RG_EPOL))   rd_word[NPINS-1:0] = epol_q;
        else if (hit(RG_LPOL))   rd_word[NPINS-1:0] = lpol_q;
        else if (hit(RG_SBLOCK)) rd_word[NPINS-1:0] = sblock_q;
        else if (hit(RG_SLEVEL)) rd_word[NPINS-1:0] = slevel_q;
        else if (hit(RG_FLEVEL)) rd_word[NPINS-1:0] = flevel_q;
        else if (hit(RG_FLAG))   rd_word[NPINS-1:0] = flag_q;
        else if (hit(RG_SEL))    rd_word[NPINS-1:0] = sel_q;
        else if (hit(RG_SOVR))   rd_word[NPINS-1:0] = sovr_q;
        else if (hit(RG_PINS))   rd_word[NPINS-1:0] = pin_sync;
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_word;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && unmapped) |=> (rdata == '0)); // R12

endmodule

// File: rtl/pinbank_events.sv
// Event detection, sticky flags and the bank interrupt.
// Assumes pin_sync is already synchronized; keeps one previous sample
// for edge detection. A detection outranks a clear on the same edge.
module pinbank_events #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] kind_q,
    input  logic [NPINS-1:0] epol_q,
    input  logic [NPINS-1:0] lpol_q,
    input  logic [NPINS-1:0] block_q,
    input  logic [NPINS-1:0] sblock_q,
    input  logic             sleep_in,
    input  logic [NPINS-1:0] flag_clr,
    output logic [NPINS-1:0] flag_q,
    output logic             irq
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] detect;
    logic [NPINS-1:0] block_eff;

    // Previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rose, fell, lvl_hit, edge_hit;
        assign rose     = pin_sync[i] & ~prev_q[i];
        assign fell     = ~pin_sync[i] & prev_q[i];
        assign edge_hit = epol_q[i] ? rose : fell;
        assign lvl_hit  = lpol_q[i] ? pin_sync[i] : ~pin_sync[i];
        assign detect[i] = kind_q[i] ? edge_hit : lvl_hit;
    end

    // Sticky flags: cleared by write-one, set by any detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | detect;
    end

    // Block source follows the mode; interrupt is any unblocked flag.
    always_comb begin
        block_eff = sleep_in ? sblock_q : block_q;
        irq       = |(flag_q & ~block_eff);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag_q) & ~$past(flag_clr) & ~flag_q) == '0)); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0)); // R11

endmodule

// File: rtl/pinbank_drive.sv
// Pin drive selection per pin: battery fault, then sleep or override,
// then peripheral select, then the normal registers.
// Assumes mode inputs are already synchronous to clk.
module pinbank_drive #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_in,
    input  logic             batt_fault_in,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] level_q,
    input  logic [NPINS-1:0] slevel_q,
    input  logic [NPINS-1:0] flevel_q,
    input  logic [NPINS-1:0] sel_q,
    input  logic [NPINS-1:0] sovr_q,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Priority selection of one pin's level and enable.
        always_comb begin
            if (batt_fault_in) begin
                pin_out[i] = flevel_q[i];
                pin_oe[i]  = dir_q[i];
            end else if (sleep_in || sovr_q[i]) begin
                pin_out[i] = slevel_q[i];
                pin_oe[i]  = dir_q[i];
            end else if (sel_q[i]) begin
                pin_out[i] = alt_out[i];
                pin_oe[i]  = alt_oe[i];
            end else begin
                pin_out[i] = level_q[i];
                pin_oe[i]  = dir_q[i];
            end
        end
    end

    AST_FAULT_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        batt_fault_in |-> (pin_out == flevel_q && pin_oe == dir_q)); // R7

    AST_SLEEP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_in && !batt_fault_in) |-> (pin_out == slevel_q && pin_oe == dir_q)); // R6

endmodule

// File: rtl/pinbank_top.sv
// Pin bank top: synchronizer, register file, event unit and drive select.
// Assumes one clock domain for bus and modes; pins are asynchronous.
module pinbank_top #(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    input  logic              sleep_in,
    input  logic              batt_fault_in,
    output logic              irq
);

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] block_q, dir_q, level_q, kind_q, epol_q, lpol_q;
    logic [NPINS-1:0] sblock_q, slevel_q, flevel_q, sel_q, sovr_q;
    logic [NPINS-1:0] flag_q, flag_clr;

    pinbank_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    pinbank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .flag_q(flag_q),
        .pin_sync(pin_sync), .block_q(block_q), .dir_q(dir_q),
        .level_q(level_q), .kind_q(kind_q), .epol_q(epol_q), .lpol_q(lpol_q),
        .sblock_q(sblock_q), .slevel_q(slevel_q), .flevel_q(flevel_q),
        .sel_q(sel_q), .sovr_q(sovr_q), .flag_clr(flag_clr)
    );

    pinbank_events #(.NPINS(NPINS)) u_events (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .kind_q(kind_q),
        .epol_q(epol_q), .lpol_q(lpol_q), .block_q(block_q),
        .sblock_q(sblock_q), .sleep_in(sleep_in), .flag_clr(flag_clr),
        .flag_q(flag_q), .irq(irq)
    );

    pinbank_drive #(.NPINS(NPINS)) u_drive (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in),
        .batt_fault_in(batt_fault_in), .dir_q(dir_q), .level_q(level_q),
        .slevel_q(slevel_q), .flevel_q(flevel_q), .sel_q(sel_q),
        .sovr_q(sovr_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

endmodule

// File: tb/tb_pinbank_top.sv
module tb_pinbank_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0, pin_out, pin_oe;
    logic [15:0] alt_out = '0, alt_oe = 16'h0001;
    logic        sleep_in = 1'b0, batt_fault_in = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .sleep_in(sleep_in),
        .batt_fault_in(batt_fault_in), .irq(irq)
    );

    // Writable offset, written value, expected read-back.
    localparam logic [37:0] VEC [13] = '{
        {6'h00, 16'h5A5A, 16'h5A5A},
        {6'h04, 16'h00F0, 16'h00F0},
        {6'h08, 16'h1234, 16'h1234},
        {6'h0C, 16'hFF00, 16'hFF00},
        {6'h10, 16'h0F0F, 16'h0F0F},
        {6'h14, 16'hF0F0, 16'hF0F0},
        {6'h18, 16'h1111, 16'h1111},
        {6'h1C, 16'h2222, 16'h2222},
        {6'h20, 16'h4444, 16'h4444},
        {6'h28, 16'h8001, 16'h8001},
        {6'h2C, 16'h0300, 16'h0300},
        {6'h30, 16'hFFFF, 16'h0000},
        {6'h34, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {16'hDEAD, d}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1..: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();

        // Table: write then read each offset (R2 R3 R12).
        for (int i = 0; i < 13; i++) begin
            wreg(VEC[i][37:32], VEC[i][31:16]);
            rreg(VEC[i][37:32], rv);
            chk($sformatf("R2/R3/R12 table entry %0d", i), rv, {16'h0, VEC[i][15:0]});
        end

        do_reset();
        chk("R1 pin_oe after reset", {16'h0, pin_oe}, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        rreg(6'h00, rv); chk("R1 block reset", rv, 32'h0000FFFF);
        rreg(6'h18, rv); chk("R1 sleep block reset", rv, 32'h0000FFFF);
        rreg(6'h04, rv); chk("R1 direction reset", rv, 32'h0);

        // R4 normal drive
        wreg(6'h04, 16'h00FF);
        wreg(6'h08, 16'h0F0F);
        chk("R4 pin_oe", {16'h0, pin_oe}, 32'h00FF);
        chk("R4 pin_out", {16'h0, pin_out}, 32'h0F0F);

        // R5 peripheral select on pins 0,1
        wreg(6'h28, 16'h0003);
        chk("R5 pin_out", {16'h0, pin_out}, 32'h0F0C);
        chk("R5 pin_oe", {16'h0, pin_oe}, 32'h00FD);

        // R6 sleep mode and per-pin override
        wreg(6'h1C, 16'hA5A5);
        sleep_in = 1'b1; idle(1);
        chk("R6 sleep pin_out", {16'h0, pin_out}, 32'hA5A5);
        chk("R6 sleep pin_oe", {16'h0, pin_oe}, 32'h00FF);
        sleep_in = 1'b0;
        wreg(6'h2C, 16'h0020);
        chk("R6 override pin_out", {16'h0, pin_out}, 32'h0F2C);
        chk("R6 override pin_oe", {16'h0, pin_oe}, 32'h00FD);

        // R7 battery fault beats sleep
        wreg(6'h20, 16'h3C3C);
        batt_fault_in = 1'b1; sleep_in = 1'b1; idle(1);
        chk("R7 fault pin_out", {16'h0, pin_out}, 32'h3C3C);
        chk("R7 fault pin_oe", {16'h0, pin_oe}, 32'h00FF);
        batt_fault_in = 1'b0; sleep_in = 1'b0;
        wreg(6'h2C, 16'h0000);
        wreg(6'h28, 16'h0000);

        // R8 edges: pins 0..7 rising, 8..15 falling
        wreg(6'h10, 16'h00FF);
        wreg(6'h0C, 16'hFFFF);
        idle(4);
        wreg(6'h24, 16'hFFFF);
        rreg(6'h24, rv); chk("R10 clear all", rv, 32'h0);
        pin_in = 16'h0101; idle(4);
        rreg(6'h24, rv); chk("R8 rising caught only", rv, 32'h0001);
        pin_in = 16'h0000; idle(4);
        rreg(6'h24, rv); chk("R8 falling caught, sticky", rv, 32'h0101);
        wreg(6'h24, 16'h0000);
        rreg(6'h24, rv); chk("R10 write zero keeps", rv, 32'h0101);
        wreg(6'h24, 16'h0001);
        rreg(6'h24, rv); chk("R10 write one clears", rv, 32'h0100);

        // R9 levels
        wreg(6'h14, 16'hFFFF);
        wreg(6'h0C, 16'h0000);
        wreg(6'h24, 16'hFFFF);
        rreg(6'h24, rv); chk("R9 high polarity, low pins", rv, 32'h0);
        pin_in = 16'h0004; idle(4);
        rreg(6'h24, rv); chk("R9 high level caught", rv, 32'h0004);
        wreg(6'h24, 16'h0004);
        rreg(6'h24, rv); chk("R10 held level re-sets", rv, 32'h0004);
        pin_in = 16'h0000; idle(4);
        wreg(6'h24, 16'hFFFF);
        rreg(6'h24, rv); chk("R10 clear after release", rv, 32'h0);
        wreg(6'h14, 16'hFFFE);
        idle(2);
        rreg(6'h24, rv); chk("R9 low level caught", rv, 32'h0001);

        // R11 interrupt and block source
        chk("R11 blocked", {31'h0, irq}, 32'h0);
        wreg(6'h00, 16'hFFFE);
        chk("R11 unblocked", {31'h0, irq}, 32'h1);
        sleep_in = 1'b1; idle(1);
        chk("R11 sleep block used", {31'h0, irq}, 32'h0);
        wreg(6'h18, 16'hFFFE);
        chk("R11 sleep unblocked", {31'h0, irq}, 32'h1);
        sleep_in = 1'b0;

        // R3 pin status
        pin_in = 16'hBEEF; idle(4);
        rreg(6'h30, rv); chk("R3 pin status", rv, 32'h0000BEEF);
        wreg(6'h30, 16'h0000);
        rreg(6'h30, rv); chk("R3 write ignored", rv, 32'h0000BEEF);

        // R12 unmapped
        wreg(6'h3C, 16'hFFFF);
        rreg(6'h00, rv); chk("R12 block unchanged", rv, 32'h0000FFFE);
        rreg(6'h04, rv); chk("R12 direction unchanged", rv, 32'h000000FF);
        rreg(6'h38, rv); chk("R12 unmapped reads zero", rv, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule